// File: doc/BRIEF.md
# Pixel Fetch Phase Sequencer

This block sets the pace at which a display pipeline pulls bytes out of screen memory and turns them into a serial pixel stream. A one-hot ring of eight positions marks where the sequencer stands within each byte period. While the display is outside its visible area, the ring is parked at its home position and the processor owns the memory. Once the active flag rises, the ring steps once per clock. A read strobe goes out on one fixed position. On the following position the returned byte is captured into a parallel-in, serial-out pixel register.

The byte being captured is put straight onto the serial output during its load cycle. Because of this, the first pixel leaves the block three clocks after the cycle in which active is first seen high. From then on each byte follows the previous one with no gap. Address generation and sync timing belong to neighbouring blocks. The memory is expected to return the byte in the clock after the read strobe and to hold it for that one clock.

Top module: `pixfetch_seq`

## Requirements
- R1: The phase ring always holds exactly one set bit out of 8 positions, and each position lasts exactly one clock.
- R2: When the active flag is sampled low, the ring is at its home position (position 0) for the next clock. While both the active flag and the running state are low, the CPU grant is high, and the read strobe, load strobe and pixel output are low.
- R3: The CPU grant falls in the same clock that the active flag rises, combinationally. It stays low through the one clock that follows the active flag being sampled low.
- R4: Call the clock in which active is first high cycle 0. The read strobe is high in cycle 2 and in every cycle 2+8k up to and including the first cycle after active falls. It is low in all other cycles.
- R5: The load strobe is high exactly one clock after each read strobe, that is in cycles 3+8k, within the same window as R4.
- R6: While active stays high, the ring advances one position per clock, so the read and load pattern repeats every 8 clocks.
- R7: During the cycle 3 load, the pixel output carries bit 7 of the data input. The first pixel therefore appears 3 clocks after active rises.
- R8: Each loaded byte is sent one bit per clock, most significant bit (bit 7) first, down to bit 0. The next byte's bit 7 follows directly. Zeros are shifted in behind each byte.
- R9: The pixel output is low from the second clock after active is sampled low, and in cycles 0 to 2 of every new run. A byte that was cut short never reappears after a restart.
- R10: The memory data input has no effect on the pixel output except in a load-strobe cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| disp_active_i | input | 1 | High during the visible part of the line |
| mem_data_i | input | 8 | Byte returned by screen memory in the clock after the read strobe |
| cpu_grant_o | output | 1 | High while the processor may use screen memory |
| mem_rd_o | output | 1 | Screen memory read strobe |
| pix_load_o | output | 1 | Pixel register load strobe |
| pix_out_o | output | 1 | Serial pixel bit |

## Verification
The bench instantiates the block with its defaults: an 8-position ring, 8-bit pixels, the read on position 2 and most-significant-bit-first output. With these values the fixed phase offsets and the 3-clock lead-in can be predicted exactly. The runs are of different lengths. Some end before the first read, some end between the read and the load, some stop in the middle of a byte, and some span many bytes. Runs are restarted after a single idle clock, which tests the one-clock hand-back of memory and the clearing of a half-sent byte. A memory model puts junk on the data input outside the load cycles, so any leak of that data onto the pixel output is visible.

// File: rtl/pixfetch_pkg.sv
package pixfetch_pkg;

   typedef enum logic {
      PF_MSB_FIRST = 1'b0,
      PF_LSB_FIRST = 1'b1
   } pf_order_e;

   typedef struct packed {
      logic grant;
      logic rd;
      logic load;
      logic hold;
   } pf_ctl_t;

endpackage

// File: rtl/pixfetch_ring.sv
module pixfetch_ring #(
   parameter int PHASES = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              go_i,
   output logic [PHASES-1:0] phase_o,
   output logic              run_o
);
   localparam logic [PHASES-1:0] HOME = {{(PHASES-1){1'b0}}, 1'b1};

   logic [PHASES-1:0] phase_q;
   logic [PHASES-1:0] phase_rot;
   logic              run_q;

   generate
      if (PHASES > 1) begin : g_rot
         assign phase_rot = {phase_q[PHASES-2:0], phase_q[PHASES-1]};
      end else begin : g_single
         assign phase_rot = phase_q;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= HOME;
         run_q   <= 1'b0;
      end else begin
         run_q <= go_i;
         if (go_i) begin
            phase_q <= phase_rot;
         end else begin
            phase_q <= HOME;
         end
      end
   end

   assign phase_o = phase_q;
   assign run_o   = run_q;
endmodule

// File: rtl/pixfetch_ctl.sv
module pixfetch_ctl
   import pixfetch_pkg::*;
#(
   parameter int PHASES = 8,
   parameter int RD_POS = 2,
   parameter int LD_POS = 3
) (
   input  logic [PHASES-1:0] phase_i,
   input  logic              run_i,
   input  logic              active_i,
   output pf_ctl_t           ctl_o
);
   always_comb begin
      ctl_o.hold  = ~run_i;
      ctl_o.grant = ~(active_i | run_i);
      ctl_o.rd    = run_i & phase_i[RD_POS];
      ctl_o.load  = run_i & phase_i[LD_POS];
   end
endmodule

// File: rtl/pixfetch_shift.sv
module pixfetch_shift
   import pixfetch_pkg::*;
#(
   parameter int        PIX_W = 8,
   parameter pf_order_e ORDER = PF_MSB_FIRST
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear_i,
   input  logic             load_i,
   input  logic [PIX_W-1:0] data_i,
   output logic             bit_o
);
   logic [PIX_W-1:0] sr_q;
   logic [PIX_W-1:0] sr_shift;
   logic [PIX_W-1:0] sr_fill;
   logic             head_bit;
   logic             sr_bit;

   generate
      if (ORDER == PF_MSB_FIRST) begin : g_msb
         assign head_bit = data_i[PIX_W-1];
         assign sr_bit   = sr_q[PIX_W-1];
         assign sr_fill  = {data_i[PIX_W-2:0], 1'b0};
         assign sr_shift = {sr_q[PIX_W-2:0], 1'b0};
      end else begin : g_lsb
         assign head_bit = data_i[0];
         assign sr_bit   = sr_q[0];
         assign sr_fill  = {1'b0, data_i[PIX_W-1:1]};
         assign sr_shift = {1'b0, sr_q[PIX_W-1:1]};
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sr_q <= '0;
      end else if (clear_i) begin
         sr_q <= '0;
      end else if (load_i) begin
         sr_q <= sr_fill;
      end else begin
         sr_q <= sr_shift;
      end
   end

   always_comb begin
      if (clear_i) begin
         bit_o = 1'b0;
      end else if (load_i) begin
         bit_o = head_bit;
      end else begin
         bit_o = sr_bit;
      end
   end
endmodule

// File: rtl/pixfetch_seq.sv
module pixfetch_seq
   import pixfetch_pkg::*;
#(
   parameter int        PHASES = 8,
   parameter int        PIX_W  = 8,
   parameter int        RD_POS = 2,
   parameter pf_order_e ORDER  = PF_MSB_FIRST
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             disp_active_i,
   input  logic [PIX_W-1:0] mem_data_i,
   output logic             cpu_grant_o,
   output logic             mem_rd_o,
   output logic             pix_load_o,
   output logic             pix_out_o
);
   localparam int LD_POS = (RD_POS + 1) % PHASES;

   generate
      if (PHASES < 2) begin : g_bad_phases
         $error("pixfetch_seq: PHASES must be at least 2");
      end
      if (PIX_W != PHASES) begin : g_bad_width
         $error("pixfetch_seq: PIX_W must equal PHASES for a gapless stream");
      end
      if (RD_POS < 1 || RD_POS > PHASES - 2) begin : g_bad_rd
         $error("pixfetch_seq: RD_POS must lie in 1..PHASES-2");
      end
   endgenerate

   logic [PHASES-1:0] ring_phase;
   logic              ring_run;
   pf_ctl_t           ctl;

   pixfetch_ring #(
      .PHASES (PHASES)
   ) u_ring (
      .clk     (clk),
      .rst_n   (rst_n),
      .go_i    (disp_active_i),
      .phase_o (ring_phase),
      .run_o   (ring_run)
   );

   pixfetch_ctl #(
      .PHASES (PHASES),
      .RD_POS (RD_POS),
      .LD_POS (LD_POS)
   ) u_ctl (
      .phase_i  (ring_phase),
      .run_i    (ring_run),
      .active_i (disp_active_i),
      .ctl_o    (ctl)
   );

   pixfetch_shift #(
      .PIX_W (PIX_W),
      .ORDER (ORDER)
   ) u_shift (
      .clk     (clk),
      .rst_n   (rst_n),
      .clear_i (ctl.hold),
      .load_i  (ctl.load),
      .data_i  (mem_data_i),
      .bit_o   (pix_out_o)
   );

   assign cpu_grant_o = ctl.grant;
   assign mem_rd_o    = ctl.rd;
   assign pix_load_o  = ctl.load;
endmodule

// File: rtl/pixfetch_seq_chk.sv
module pixfetch_seq_chk #(
   parameter int PHASES = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              active_i,
   input logic [PHASES-1:0] phase_i,
   input logic              run_i,
   input logic              grant_i,
   input logic              rd_i,
   input logic              load_i,
   input logic              pix_i
);
   p_ring_onehot_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot(phase_i));

   p_hold_home_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !active_i |=> (phase_i[0] && !run_i));

   p_grant_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
      grant_i |-> (!rd_i && !load_i && !pix_i));

   p_grant_drop_r3: assert property (@(posedge clk) disable iff (!rst_n)
      active_i |-> !grant_i);

   p_read_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
      rd_i |=> !rd_i);

   p_load_after_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_i && active_i) |=> load_i);

   p_advance_r6: assert property (@(posedge clk) disable iff (!rst_n)
      active_i |=> (phase_i == {$past(phase_i[PHASES-2:0]), $past(phase_i[PHASES-1])}));

   p_dark_after_stop_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !active_i |=> !pix_i);
endmodule

bind pixfetch_seq pixfetch_seq_chk #(
   .PHASES (PHASES)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .active_i (disp_active_i),
   .phase_i  (ring_phase),
   .run_i    (ring_run),
   .grant_i  (cpu_grant_o),
   .rd_i     (mem_rd_o),
   .load_i   (pix_load_o),
   .pix_i    (pix_out_o)
);

// File: tb/pixfetch_seq_tb_top.sv
`timescale 1ns/1ps
module pixfetch_seq_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       act = 1'b0;
   logic [7:0] mdata = 8'h00;
   logic       grant, rd, ld, pix;

   int   n_chk = 0;
   int   n_bad = 0;
   int   ph_c = -1;
   logic last_rd = 1'b0;
   logic mon_on = 1'b0;
   logic done = 1'b0;
   logic [7:0] seq = 8'h3C;
   bit   exp_q[$];

   always #2 clk = ~clk;

   pixfetch_seq dut_i (
      .clk           (clk),
      .rst_n         (rst_n),
      .disp_active_i (act),
      .mem_data_i    (mdata),
      .cpu_grant_o   (grant),
      .mem_rd_o      (rd),
      .pix_load_o    (ld),
      .pix_out_o     (pix)
   );

   task automatic chk(input bit ok, input string tag, input int av, input int ev);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d cycle=%0d t=%0t", tag, av, ev, ph_c, $time);
      end
   endtask

   // driver: one clock of stimulus plus the memory model
   task automatic step(input logic a, input int c);
      @(posedge clk);
      #1;
      act  = a;
      ph_c = c;
      if (c == 0) exp_q.delete();
      if (last_rd) begin
         seq   = seq * 8'd29 + 8'd71;
         mdata = seq;
         if (c >= 3) begin
            for (int i = 7; i >= 0; i--) exp_q.push_back(seq[i]);
         end
      end else begin
         mdata = {seq[3:0], seq[7:4]} ^ 8'hC3 ^ c[7:0];
      end
   endtask

   task automatic run_burst(input int len, input int gap);
      for (int c = 0; c < len; c++) step(1'b1, c);
      step(1'b0, len);
      for (int g = 1; g < gap; g++) step(1'b0, -1);
   endtask

   // monitor: compares ports against expectations away from the edge
   always @(negedge clk) begin
      if (mon_on && !done) begin
         bit e_grant, e_rd, e_ld, e_pix;
         e_grant = (ph_c < 0);
         e_rd    = (ph_c >= 2) && (((ph_c - 2) % 8) == 0);
         e_ld    = (ph_c >= 3) && (((ph_c - 3) % 8) == 0);
         chk(grant == e_grant, "R2 R3 cpu grant", grant, e_grant);
         chk(rd == e_rd, "R4 R6 read strobe", rd, e_rd);
         chk(ld == e_ld, "R5 R6 load strobe", ld, e_ld);
         if (ph_c >= 3) begin
            if (exp_q.size() == 0) begin
               chk(1'b0, "R7 R8 scoreboard empty", pix, 0);
            end else begin
               e_pix = exp_q.pop_front();
               chk(pix == e_pix, "R7 R8 R10 pixel bit", pix, e_pix);
            end
         end else begin
            chk(pix == 1'b0, "R9 pixel dark", pix, 0);
         end
         last_rd = rd;
      end
   end

   initial begin
      #(4 * 200000);
      if (!done) begin
         chk(1'b0, "watchdog expired", 0, 1);
         done = 1'b1;
         $display("test done: total=%0d bad=%0d", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk(grant == 1'b1, "R2 reset grant", grant, 1);
      chk(rd == 1'b0, "R2 reset read", rd, 0);
      chk(ld == 1'b0, "R2 reset load", ld, 0);
      chk(pix == 1'b0, "R9 reset pixel", pix, 0);
      @(posedge clk);
      #1;
      rst_n  = 1'b1;
      mon_on = 1'b1;
      for (int i = 0; i < 3; i++) step(1'b0, -1);
      run_burst(40, 3);
      run_burst(20, 1);
      run_burst(3, 2);
      run_burst(2, 1);
      run_burst(1, 1);
      run_burst(11, 1);
      run_burst(4, 5);
      run_burst(64, 4);
      for (int i = 0; i < 4; i++) step(1'b0, -1);
      @(posedge clk);
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end
endmodule